// File: doc/BRIEF.md
# Integer Execute Stage with HI/LO Moves

This block is the execute step of a 32-bit load/store integer pipeline. For each decoded operation it receives the major opcode, the function field, the immediate shift count, the 16-bit immediate, the destination register index, both source register values and the current HI and LO values. It returns the value to write back, a register write strobe, and separate write strobes and values for HI and LO. It covers addition and subtraction, signed and unsigned set-less-than, bitwise logic, fixed and variable shifts, load-upper-immediate, HI/LO transfers and the two conditional moves. Overflow traps, multiply/divide, memory access and branches belong to other stages.

Operations enter on a valid/ready stream and leave on a second valid/ready stream after one register stage. An operation is taken when `in_valid` and `in_ready` are both high at a clock edge. A result is consumed when `out_valid` and `out_ready` are both high. While a result waits, the stage takes nothing new, so back-pressure from the consumer reaches the producer in the same cycle. An operation that carries an unrecognised encoding still passes through the stage, but it writes nothing.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, function 32 (add) and 33 (add, no trap) return rs+rt, and 34 and 35 return rs-rt, all modulo 2^32. Opcodes 8 and 9 return rs plus the sign-extended immediate.
- R2: Function 42 and opcode 10 compare signed; function 43 and opcode 11 compare unsigned. The second operand is rt for the functions and the sign-extended immediate for the opcodes. The result is 1 when rs is less, otherwise 0.
- R3: Functions 36, 37, 38 and 39 return rs AND, OR, XOR and NOR rt. Opcodes 12, 13 and 14 return rs AND, OR and XOR the zero-extended immediate.
- R4: Functions 0, 2 and 3 shift rt by the 5-bit shift-count field: left, right logical, and right arithmetic with sign fill.
- R5: Functions 4, 6 and 7 shift rt in the same three ways. The shift count is rs[4:0], and the upper bits of rs are ignored.
- R6: Opcode 15 returns the immediate in bits 31:16 and zero in bits 15:0.
- R7: Functions 16 and 18 return HI and LO and write the register. Functions 17 and 19 write rs into HI or LO with its own strobe, and they raise no register write. At most one HI/LO strobe is set.
- R8: Function 10 writes rs only when rt is zero. Function 11 writes rs only when rt is nonzero. Otherwise the register strobe stays low.
- R9: The register strobe is never set for destination index 0.
- R10: Any opcode outside {0, 8..15}, and any opcode-0 function not listed above, raises no strobe.
- R11: `in_ready` is high exactly when no result is waiting or the waiting result is being taken. A result that is waiting with `out_ready` low keeps all of its output fields unchanged.
- R12: An operation taken at one edge is presented with `out_valid` high right after that edge. After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Stage can take an operation |
| in_opcode | input | 6 | Major opcode |
| in_funct | input | 6 | Function field (opcode 0) |
| in_shamt | input | 5 | Immediate shift count |
| in_imm | input | 16 | Immediate field |
| in_dest | input | 5 | Destination register index |
| in_rs | input | 32 | First source value |
| in_rt | input | 32 | Second source value |
| in_hi | input | 32 | Current HI |
| in_lo | input | 32 | Current LO |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | 32 | Write-back value |
| out_dest | output | 5 | Destination register index |
| out_reg_we | output | 1 | Register write strobe |
| out_hi_we | output | 1 | HI write strobe |
| out_hi | output | 32 | New HI value |
| out_lo_we | output | 1 | LO write strobe |
| out_lo | output | 32 | New LO value |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, 16-bit immediates and 5-bit register indices. At these values the sign-fill pattern 0x800000F0 >>> 3, shift counts taken modulo 32 from an rs of 0x23, and the immediate sign boundary at 0xFFFF and 0x8000 can all be reached. The whole operation set runs twice, once with the consumer always ready and once with a stalling consumer. The second pass exercises holding a waiting result and the ready path.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int unsigned OPC_W = 6;
  localparam int unsigned FUN_W = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [FUN_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FUN_W-1:0] FN_SRL  = 6'd2;
  localparam logic [FUN_W-1:0] FN_SRA  = 6'd3;
  localparam logic [FUN_W-1:0] FN_SLLV = 6'd4;
  localparam logic [FUN_W-1:0] FN_SRLV = 6'd6;
  localparam logic [FUN_W-1:0] FN_SRAV = 6'd7;
  localparam logic [FUN_W-1:0] FN_MOVZ = 6'd10;
  localparam logic [FUN_W-1:0] FN_MOVN = 6'd11;
  localparam logic [FUN_W-1:0] FN_MFHI = 6'd16;
  localparam logic [FUN_W-1:0] FN_MTHI = 6'd17;
  localparam logic [FUN_W-1:0] FN_MFLO = 6'd18;
  localparam logic [FUN_W-1:0] FN_MTLO = 6'd19;
  localparam logic [FUN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FUN_W-1:0] FN_ADDU = 6'd33;
  localparam logic [FUN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FUN_W-1:0] FN_SUBU = 6'd35;
  localparam logic [FUN_W-1:0] FN_AND  = 6'd36;
  localparam logic [FUN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FUN_W-1:0] FN_XOR  = 6'd38;
  localparam logic [FUN_W-1:0] FN_NOR  = 6'd39;
  localparam logic [FUN_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FUN_W-1:0] FN_SLTU = 6'd43;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI,
    ALU_PASS_RS, ALU_HI, ALU_LO
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    src_imm;      // second operand is the immediate
    logic    imm_sext;     // immediate sign-extended (else zero-extended)
    logic    shift_var;    // shift count from rs instead of shamt
    logic    wr_reg;
    logic    wr_hi;
    logic    wr_lo;
    logic    need_zero;    // write only if rt == 0
    logic    need_nonzero; // write only if rt != 0
  } exu_ctl_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FUN_W-1:0] funct,
  output exu_ctl_t         ctl
);

  always_comb begin
    ctl = '{op: ALU_ADD, default: 1'b0};
    if (opcode == OPC_REG) begin
      ctl.wr_reg = 1'b1;
      unique case (funct)
        FN_ADD, FN_ADDU: ctl.op = ALU_ADD;
        FN_SUB, FN_SUBU: ctl.op = ALU_SUB;
        FN_AND:          ctl.op = ALU_AND;
        FN_OR:           ctl.op = ALU_OR;
        FN_XOR:          ctl.op = ALU_XOR;
        FN_NOR:          ctl.op = ALU_NOR;
        FN_SLT:          ctl.op = ALU_SLT;
        FN_SLTU:         ctl.op = ALU_SLTU;
        FN_SLL:          ctl.op = ALU_SLL;
        FN_SRL:          ctl.op = ALU_SRL;
        FN_SRA:          ctl.op = ALU_SRA;
        FN_SLLV: begin ctl.op = ALU_SLL; ctl.shift_var = 1'b1; end
        FN_SRLV: begin ctl.op = ALU_SRL; ctl.shift_var = 1'b1; end
        FN_SRAV: begin ctl.op = ALU_SRA; ctl.shift_var = 1'b1; end
        FN_MFHI:         ctl.op = ALU_HI;
        FN_MFLO:         ctl.op = ALU_LO;
        FN_MTHI: begin ctl.op = ALU_PASS_RS; ctl.wr_reg = 1'b0; ctl.wr_hi = 1'b1; end
        FN_MTLO: begin ctl.op = ALU_PASS_RS; ctl.wr_reg = 1'b0; ctl.wr_lo = 1'b1; end
        FN_MOVZ: begin ctl.op = ALU_PASS_RS; ctl.need_zero    = 1'b1; end
        FN_MOVN: begin ctl.op = ALU_PASS_RS; ctl.need_nonzero = 1'b1; end
        default:         ctl.wr_reg = 1'b0;
      endcase
    end else begin
      ctl.src_imm = 1'b1;
      ctl.wr_reg  = 1'b1;
      unique case (opcode)
        OPC_ADDI, OPC_ADDIU: begin ctl.op = ALU_ADD;  ctl.imm_sext = 1'b1; end
        OPC_SLTI:            begin ctl.op = ALU_SLT;  ctl.imm_sext = 1'b1; end
        OPC_SLTIU:           begin ctl.op = ALU_SLTU; ctl.imm_sext = 1'b1; end
        OPC_ANDI:            ctl.op = ALU_AND;
        OPC_ORI:             ctl.op = ALU_OR;
        OPC_XORI:            ctl.op = ALU_XOR;
        OPC_LUI:             ctl.op = ALU_LUI;
        default: begin ctl.wr_reg = 1'b0; ctl.src_imm = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  exu_ctl_t          ctl,
  input  logic [SH_W-1:0]   shamt,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] rs,
  input  logic [DATA_W-1:0] rt,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opb;
  logic [SH_W-1:0]   sh_cnt;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic              lt_s;
  logic              lt_u;

  assign imm_ext = ctl.imm_sext ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
  assign opb     = ctl.src_imm ? imm_ext : rt;
  assign sh_cnt  = ctl.shift_var ? rs[SH_W-1:0] : shamt;
  assign sum     = rs + opb;
  assign diff    = rs - opb;
  assign lt_s    = $signed(rs) < $signed(opb);
  assign lt_u    = rs < opb;

  always_comb begin
    unique case (ctl.op)
      ALU_ADD:     result = sum;
      ALU_SUB:     result = diff;
      ALU_AND:     result = rs & opb;
      ALU_OR:      result = rs | opb;
      ALU_XOR:     result = rs ^ opb;
      ALU_NOR:     result = ~(rs | opb);
      ALU_SLT:     result = {{(DATA_W-1){1'b0}}, lt_s};
      ALU_SLTU:    result = {{(DATA_W-1){1'b0}}, lt_u};
      ALU_SLL:     result = rt << sh_cnt;
      ALU_SRL:     result = rt >> sh_cnt;
      ALU_SRA:     result = $unsigned($signed(rt) >>> sh_cnt);
      ALU_LUI:     result = {imm, {EXT_W{1'b0}}};
      ALU_PASS_RS: result = rs;
      ALU_HI:      result = hi;
      ALU_LO:      result = lo;
      default:     result = '0;
    endcase
  end

endmodule

// File: rtl/exu_pipe_reg.sv
module exu_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IMM_W     = 16,
  parameter int unsigned REG_IDX_W = 5,
  localparam int unsigned SH_W     = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OPC_W-1:0]     in_opcode,
  input  logic [FUN_W-1:0]     in_funct,
  input  logic [SH_W-1:0]      in_shamt,
  input  logic [IMM_W-1:0]     in_imm,
  input  logic [REG_IDX_W-1:0] in_dest,
  input  logic [DATA_W-1:0]    in_rs,
  input  logic [DATA_W-1:0]    in_rt,
  input  logic [DATA_W-1:0]    in_hi,
  input  logic [DATA_W-1:0]    in_lo,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_result,
  output logic [REG_IDX_W-1:0] out_dest,
  output logic                 out_reg_we,
  output logic                 out_hi_we,
  output logic [DATA_W-1:0]    out_hi,
  output logic                 out_lo_we,
  output logic [DATA_W-1:0]    out_lo
);

  localparam int unsigned PKT_W = 3 * DATA_W + REG_IDX_W + 3;

  exu_ctl_t          ctl;
  logic [DATA_W-1:0] alu_res;
  logic              cond_ok;
  logic              reg_we;
  logic [PKT_W-1:0]  pkt_in;
  logic [PKT_W-1:0]  pkt_out;

  exu_decode u_decode (
    .opcode (in_opcode),
    .funct  (in_funct),
    .ctl    (ctl)
  );

  exu_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .ctl    (ctl),
    .shamt  (in_shamt),
    .imm    (in_imm),
    .rs     (in_rs),
    .rt     (in_rt),
    .hi     (in_hi),
    .lo     (in_lo),
    .result (alu_res)
  );

  // Conditional moves gate the strobe; writes to index 0 are dropped.
  assign cond_ok = !(ctl.need_zero && (in_rt != '0)) && !(ctl.need_nonzero && (in_rt == '0));
  assign reg_we  = ctl.wr_reg && cond_ok && (in_dest != '0);

  assign pkt_in = {alu_res, in_dest, reg_we, ctl.wr_hi, in_rs, ctl.wr_lo, in_rs};

  exu_pipe_reg #(.W(PKT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pkt_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pkt_out)
  );

  assign {out_result, out_dest, out_reg_we, out_hi_we, out_hi, out_lo_we, out_lo} = pkt_out;

endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [5:0]           in_opcode,
  input logic [5:0]           in_funct,
  input logic [DATA_W-1:0]    in_rt,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_W-1:0]    out_result,
  input logic [REG_IDX_W-1:0] out_dest,
  input logic                 out_reg_we,
  input logic                 out_hi_we,
  input logic                 out_lo_we
);

  logic take;
  assign take = in_valid && in_ready;

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dest) && $stable(out_reg_we)); // R11
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11
  AST_TAKE_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R12
  AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_reg_we && out_dest == '0)); // R9
  AST_HILO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_hi_we, out_lo_we})); // R7
  AST_HILO_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_hi_we || out_lo_we) |-> !out_reg_we); // R7
  AST_MOVZ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_opcode == 6'd0 && in_funct == 6'd10 && in_rt != '0 |=> !out_reg_we); // R8
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_opcode != 6'd0 && (in_opcode < 6'd8 || in_opcode > 6'd15)
      |=> !out_reg_we && !out_hi_we && !out_lo_we); // R10

endmodule

bind int_exec_unit exu_checker #(.DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W)) i_exu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_funct   (in_funct),
  .in_rt      (in_rt),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_dest   (out_dest),
  .out_reg_we (out_reg_we),
  .out_hi_we  (out_hi_we),
  .out_lo_we  (out_lo_we)
);

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [5:0]  in_funct = '0;
  logic [4:0]  in_shamt = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_dest = '0;
  logic [31:0] in_rs = '0, in_rt = '0, in_hi = '0, in_lo = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result, out_hi, out_lo;
  logic [4:0]  out_dest;
  logic        out_reg_we, out_hi_we, out_lo_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit bp_en   = 1'b0;
  bit done    = 1'b0;

  typedef struct packed {
    logic [31:0] res;
    logic [4:0]  dest;
    logic        we;
    logic        hwe;
    logic [31:0] hv;
    logic        lwe;
    logic [31:0] lv;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_funct(in_funct), .in_shamt(in_shamt), .in_imm(in_imm),
    .in_dest(in_dest), .in_rs(in_rs), .in_rt(in_rt), .in_hi(in_hi), .in_lo(in_lo),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result), .out_dest(out_dest),
    .out_reg_we(out_reg_we), .out_hi_we(out_hi_we), .out_hi(out_hi),
    .out_lo_we(out_lo_we), .out_lo(out_lo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Driver: presents one operation, records its expected outcome.
  task automatic send(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
                      input logic [15:0] imm, input logic [4:0] dst,
                      input logic [31:0] rs, input logic [31:0] rt,
                      input logic [31:0] hi, input logic [31:0] lo,
                      input bit we, input logic [31:0] res,
                      input bit hwe, input bit lwe, input string req);
    exp_t e;
    @(negedge clk);
    in_opcode = op; in_funct = fn; in_shamt = sh; in_imm = imm; in_dest = dst;
    in_rs = rs; in_rt = rt; in_hi = hi; in_lo = lo; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.res = res; e.dest = dst; e.we = we; e.hwe = hwe; e.hv = rs; e.lwe = lwe; e.lv = rs;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(posedge clk);
    #1;
    chk(out_valid === 1'b1, "R12", "valid after take", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
  endtask

  // Monitor: pops expectations as results are consumed; checks holding while stalled.
  initial begin : monitor
    bit          was_stall = 1'b0;
    logic [31:0] held = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (was_stall && out_valid)
          chk(out_result === held, "R11", "held result while stalled", out_result, held);
        if (out_valid && out_ready) begin
          exp_t  e;
          string t;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R12", "unexpected result", out_result, 32'd0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_reg_we === e.we, t, "reg write strobe", {31'd0, out_reg_we}, {31'd0, e.we});
            if (e.we) begin
              chk(out_result === e.res, t, "result", out_result, e.res);
              chk(out_dest === e.dest, t, "dest", {27'd0, out_dest}, {27'd0, e.dest});
            end
            chk(out_hi_we === e.hwe, t, "hi strobe", {31'd0, out_hi_we}, {31'd0, e.hwe});
            chk(out_lo_we === e.lwe, t, "lo strobe", {31'd0, out_lo_we}, {31'd0, e.lwe});
            if (e.hwe) chk(out_hi === e.hv, t, "hi value", out_hi, e.hv);
            if (e.lwe) chk(out_lo === e.lv, t, "lo value", out_lo, e.lv);
          end
        end
        was_stall = out_valid && !out_ready;
        held = out_result;
      end
    end
  end

  // Consumer back-pressure pattern.
  initial begin : consumer
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      out_ready = bp_en ? (cnt % 3 != 0) : 1'b1;
    end
  end

  task automatic run_all();
    // R1 add / subtract
    send(6'd0, 6'd32, 5'd0, 16'h0, 5'd26, 32'd24, 32'd12, 0, 0, 1, 32'd36, 0, 0, "R1");
    send(6'd0, 6'd33, 5'd0, 16'h0, 5'd26, 32'd24, 32'd12, 0, 0, 1, 32'd36, 0, 0, "R1");
    send(6'd0, 6'd34, 5'd0, 16'h0, 5'd26, 32'd24, 32'd12, 0, 0, 1, 32'd12, 0, 0, "R1");
    send(6'd0, 6'd35, 5'd0, 16'h0, 5'd26, 32'd12, 32'd24, 0, 0, 1, 32'hFFFFFFF4, 0, 0, "R1");
    send(6'd8, 6'd0, 5'd0, 16'd12, 5'd26, 32'd24, 32'd0, 0, 0, 1, 32'd36, 0, 0, "R1");
    send(6'd8, 6'd0, 5'd0, 16'hFFFC, 5'd26, 32'd24, 32'd0, 0, 0, 1, 32'd20, 0, 0, "R1");
    send(6'd9, 6'd0, 5'd0, 16'hFFFF, 5'd26, 32'd0, 32'd0, 0, 0, 1, 32'hFFFFFFFF, 0, 0, "R1");
    // R2 compares
    send(6'd0, 6'd42, 5'd0, 16'h0, 5'd26, 32'd12, 32'd24, 0, 0, 1, 32'd1, 0, 0, "R2");
    send(6'd0, 6'd42, 5'd0, 16'h0, 5'd26, 32'hFFFFFFFF, 32'd1, 0, 0, 1, 32'd1, 0, 0, "R2");
    send(6'd0, 6'd43, 5'd0, 16'h0, 5'd26, 32'hFFFFFFFF, 32'd1, 0, 0, 1, 32'd0, 0, 0, "R2");
    send(6'd10, 6'd0, 5'd0, 16'd24, 5'd26, 32'd12, 32'd0, 0, 0, 1, 32'd1, 0, 0, "R2");
    send(6'd10, 6'd0, 5'd0, 16'hFFFF, 5'd26, 32'd5, 32'd0, 0, 0, 1, 32'd0, 0, 0, "R2");
    send(6'd11, 6'd0, 5'd0, 16'hFFFF, 5'd26, 32'd5, 32'd0, 0, 0, 1, 32'd1, 0, 0, "R2");
    // R3 logic
    send(6'd0, 6'd36, 5'd0, 16'h0, 5'd26, 32'hF0, 32'hE1, 0, 0, 1, 32'hE0, 0, 0, "R3");
    send(6'd0, 6'd37, 5'd0, 16'h0, 5'd26, 32'hF0, 32'hE1, 0, 0, 1, 32'hF1, 0, 0, "R3");
    send(6'd0, 6'd38, 5'd0, 16'h0, 5'd26, 32'hF0, 32'hE1, 0, 0, 1, 32'h11, 0, 0, "R3");
    send(6'd0, 6'd39, 5'd0, 16'h0, 5'd26, 32'hF0, 32'hE1, 0, 0, 1, 32'hFFFFFF0E, 0, 0, "R3");
    send(6'd12, 6'd0, 5'd0, 16'h80E1, 5'd26, 32'hFFFFFFFF, 32'd0, 0, 0, 1, 32'h000080E1, 0, 0, "R3");
    send(6'd13, 6'd0, 5'd0, 16'hE1, 5'd26, 32'hF0, 32'd0, 0, 0, 1, 32'hF1, 0, 0, "R3");
    send(6'd14, 6'd0, 5'd0, 16'h8000, 5'd26, 32'd0, 32'd0, 0, 0, 1, 32'h00008000, 0, 0, "R3");
    // R4 fixed shifts
    send(6'd0, 6'd0, 5'd3, 16'h0, 5'd26, 32'd0, 32'hF0, 0, 0, 1, 32'h780, 0, 0, "R4");
    send(6'd0, 6'd2, 5'd3, 16'h0, 5'd26, 32'd0, 32'hF0, 0, 0, 1, 32'h1E, 0, 0, "R4");
    send(6'd0, 6'd2, 5'd3, 16'h0, 5'd26, 32'd0, 32'h800000F0, 0, 0, 1, 32'h1000001E, 0, 0, "R4");
    send(6'd0, 6'd3, 5'd3, 16'h0, 5'd26, 32'd0, 32'h800000F0, 0, 0, 1, 32'hF000001E, 0, 0, "R4");
    // R5 variable shifts
    send(6'd0, 6'd4, 5'd0, 16'h0, 5'd26, 32'd3, 32'hF0, 0, 0, 1, 32'h780, 0, 0, "R5");
    send(6'd0, 6'd4, 5'd0, 16'h0, 5'd26, 32'h23, 32'hF0, 0, 0, 1, 32'h780, 0, 0, "R5");
    send(6'd0, 6'd6, 5'd0, 16'h0, 5'd26, 32'd3, 32'hF0, 0, 0, 1, 32'h1E, 0, 0, "R5");
    send(6'd0, 6'd7, 5'd0, 16'h0, 5'd26, 32'd3, 32'h800000F0, 0, 0, 1, 32'hF000001E, 0, 0, "R5");
    // R6 load upper
    send(6'd15, 6'd0, 5'd0, 16'hF00F, 5'd26, 32'h1234, 32'd0, 0, 0, 1, 32'hF00F0000, 0, 0, "R6");
    // R7 HI/LO
    send(6'd0, 6'd16, 5'd0, 16'h0, 5'd26, 32'd0, 32'd0, 32'd24, 32'd28, 1, 32'd24, 0, 0, "R7");
    send(6'd0, 6'd18, 5'd0, 16'h0, 5'd26, 32'd0, 32'd0, 32'd24, 32'd28, 1, 32'd28, 0, 0, "R7");
    send(6'd0, 6'd17, 5'd0, 16'h0, 5'd26, 32'd21, 32'd0, 32'd24, 32'd28, 0, 32'd0, 1, 0, "R7");
    send(6'd0, 6'd19, 5'd0, 16'h0, 5'd26, 32'd22, 32'd0, 32'd24, 32'd28, 0, 32'd0, 0, 1, "R7");
    // R8 conditional moves
    send(6'd0, 6'd10, 5'd0, 16'h0, 5'd25, 32'd55, 32'd0, 0, 0, 1, 32'd55, 0, 0, "R8");
    send(6'd0, 6'd10, 5'd0, 16'h0, 5'd25, 32'd55, 32'd1, 0, 0, 0, 32'd0, 0, 0, "R8");
    send(6'd0, 6'd11, 5'd0, 16'h0, 5'd25, 32'd55, 32'd24, 0, 0, 1, 32'd55, 0, 0, "R8");
    send(6'd0, 6'd11, 5'd0, 16'h0, 5'd25, 32'd55, 32'd0, 0, 0, 0, 32'd0, 0, 0, "R8");
    // R9 destination zero
    send(6'd0, 6'd32, 5'd0, 16'h0, 5'd0, 32'd1, 32'd2, 0, 0, 0, 32'd0, 0, 0, "R9");
    send(6'd15, 6'd0, 5'd0, 16'h1, 5'd0, 32'd0, 32'd0, 0, 0, 0, 32'd0, 0, 0, "R9");
    // R10 unknown encodings
    send(6'd0, 6'd1, 5'd0, 16'h0, 5'd26, 32'd1, 32'd2, 0, 0, 0, 32'd0, 0, 0, "R10");
    send(6'd0, 6'd63, 5'd0, 16'h0, 5'd26, 32'd1, 32'd2, 0, 0, 0, 32'd0, 0, 0, "R10");
    send(6'd5, 6'd32, 5'd0, 16'h0, 5'd26, 32'd1, 32'd2, 0, 0, 0, 32'd0, 0, 0, "R10");
    send(6'd35, 6'd0, 5'd0, 16'h4, 5'd26, 32'd1, 32'd2, 0, 0, 0, 32'd0, 0, 0, "R10");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R12 watchdog expired: actual %0d expected %0d pending", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1;
    chk(out_valid === 1'b0, "R12", "valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid === 1'b0, "R12", "valid after reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready === 1'b1, "R11", "ready after reset", {31'd0, in_ready}, 32'd1);
    run_all();
    bp_en = 1'b1;
    run_all();
    repeat (6) @(posedge clk);
    bp_en = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule